// File: doc/BRIEF.md
# Embedded Logic Analyzer Capture Engine

This block watches a bundle of internal probe signals and records one sample of them per clock into an on-chip trace memory used as a ring. Programmable per-probe comparators decide when the trigger fires. The capture keeps a chosen number of samples that came before the trigger, then fills the rest of its window and stops. The memory can be split into several equal windows, each one filled by its own trigger occurrence.

A storage qualifier can limit writes to the cycles of interest. The engine can also re-arm itself once the host has drained a finished capture. Readout is by logical index. Each window is returned oldest sample first, whatever ring position the trigger happened to land on.

Top module: `la_capture`

## Requirements
- R1: After reset `status_o` reads 0 (idle). The status codes are 0 idle, 1 armed and waiting for the trigger, 2 post-trigger filling, and 3 done.
- R2: A pulse on `arm_i` while the status is idle or done moves the status to armed on the next cycle. `abort_i` takes priority over `arm_i`.
- R3: Each probe p (bits `[PW*p +: PW]` of `probe_i`) has a 2-bit mode field in `trig_mode_i[2p+1:2p]`. The codes are: 0 ignore, 1 equal to the constant in `trig_val_i[PW*p +: PW]`, 2 unsigned greater than that constant, and 3 rising edge of the probe's bit 0 (previous sample 0, current sample 1). The trigger is the AND of all probe results.
- R4: The pre-trigger setting `pretrig_i` places the trigger sample at index `pretrig_i` of its window, with that many older samples before it. A setting larger than the window length minus one is clamped to the window length minus one.
- R5: A trigger match is ignored until at least `pretrig_i` samples have been stored since the window began.
- R6: After the trigger, the engine passes through status 2 and writes samples until the window holds exactly its length. It then stops and reports 3 once every window is full.
- R7: A read of logical address a (asserted with `rd_en_i`) returns data on `rd_data_o` one cycle later. Window w = a / window length, and the index within the window is a mod window length. Index 0 is the oldest sample, so consecutive addresses come out in chronological order.
- R8: With `seg_log2_i` = k (clamped to the maximum), the memory forms 2^k windows of DEPTH/2^k samples. The windows are filled in address order, each by a separate trigger occurrence.
- R9: With `qual_en_i` high, a sample is stored only on cycles where every qualifier comparator (`qual_mode_i`/`qual_val_i`, coded as in R3) matches. The trigger only counts on stored samples.
- R10: With `auto_rearm_i` high in the done state, a read of the last logical address (all ones) re-arms the engine on the next cycle. With it low, the status stays 3.
- R11: `abort_i` returns the status to idle on the next cycle from any state.
- R12: In the idle state without `arm_i`, the engine stays idle and ignores trigger matches. In the done state with no arm, abort or read, it stays done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_i | input | NPROBE*PW | Probe bundle, probe p in bits [PW*p +: PW] |
| arm_i | input | 1 | Start a capture (pulse) |
| abort_i | input | 1 | Return to idle (pulse) |
| auto_rearm_i | input | 1 | Re-arm after the last address is read |
| seg_log2_i | input | KW | log2 of the window count |
| pretrig_i | input | AW+1 | Samples kept before the trigger |
| trig_mode_i | input | 2*NPROBE | Trigger comparator modes |
| trig_val_i | input | NPROBE*PW | Trigger comparator constants |
| qual_en_i | input | 1 | Enable the storage qualifier |
| qual_mode_i | input | 2*NPROBE | Qualifier comparator modes |
| qual_val_i | input | NPROBE*PW | Qualifier comparator constants |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | AW | Logical read address |
| rd_data_o | output | NPROBE*PW | Read data, one cycle after the strobe |
| status_o | output | 2 | Engine status |

## Verification
The hardest case to reach from the ports is a trigger match that arrives before the pre-trigger region has been filled. The match must be skipped, and the capture must land on a later occurrence instead. The bench feeds the probes an incrementing count and arms just a few values before a matching count, so the first match falls short of the required sample count while the next one qualifies. Every captured window is then predicted arithmetically from the count value at arming, which also covers qualified, segmented and auto re-armed captures.

// File: rtl/la_pkg.sv
package la_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FILL  = 2'd2,
    ST_DONE  = 2'd3
  } la_state_e;

  typedef enum logic [1:0] {
    CMP_ANY  = 2'd0,
    CMP_EQ   = 2'd1,
    CMP_GT   = 2'd2,
    CMP_RISE = 2'd3
  } la_cmp_e;
endpackage

// File: rtl/la_match.sv
module la_match
  import la_pkg::*;
#(
  parameter int PW     = 4,
  parameter int NPROBE = 2
) (
  input  logic [NPROBE*PW-1:0] cur_i,
  input  logic [NPROBE-1:0]    prev_bit_i,
  input  logic [2*NPROBE-1:0]  mode_i,
  input  logic [NPROBE*PW-1:0] val_i,
  output logic                 hit_o
);
  logic [NPROBE-1:0] ok;

  for (genvar p = 0; p < NPROBE; p++) begin : g_probe
    logic [PW-1:0] cur_p, val_p;
    logic          ok_p;
    assign cur_p = cur_i[PW*p +: PW];
    assign val_p = val_i[PW*p +: PW];
    always_comb begin
      case (la_cmp_e'(mode_i[2*p +: 2]))
        CMP_EQ:   ok_p = (cur_p == val_p);
        CMP_GT:   ok_p = (cur_p > val_p);
        CMP_RISE: ok_p = ~prev_bit_i[p] & cur_p[0];
        default:  ok_p = 1'b1;
      endcase
    end
    assign ok[p] = ok_p;
  end

  assign hit_o = &ok;
endmodule

// File: rtl/la_trace_ram.sv
module la_trace_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/la_ctrl.sv
module la_ctrl
  import la_pkg::*;
#(
  parameter int DEPTH        = 1024,
  parameter int MAX_SEG_LOG2 = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int KW   = $clog2(MAX_SEG_LOG2 + 1),
  localparam int SIW  = MAX_SEG_LOG2,
  localparam int NSEG = 1 << MAX_SEG_LOG2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_i,
  input  logic          abort_i,
  input  logic          auto_i,
  input  logic [KW-1:0] cfg_k_i,
  input  logic [AW:0]   cfg_pre_i,
  input  logic          qual_en_i,
  input  logic          qual_hit_i,
  input  logic          trig_hit_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_phys_o,
  output la_state_e     state_o
);
  la_state_e     state_q;
  logic [AW-1:0] wp_q, stored_q, rem_q, pre_q;
  logic [KW-1:0] k_q;
  logic [SIW-1:0] seg_q;
  logic [AW-1:0] start_q [NSEG];

  logic [AW-1:0] seg_mask, mask_in, pre_in, post_len, wp_nxt;
  logic [KW-1:0] k_in;
  logic [SIW:0]  seg_cnt;
  logic [SIW-1:0] rd_w;
  logic          active, we, ready, take, fill_last, win_end, last_seg;
  logic          rearm, begin_run;

  always_comb begin
    seg_mask  = {AW{1'b1}} >> k_q;
    k_in      = (cfg_k_i > KW'(MAX_SEG_LOG2)) ? KW'(MAX_SEG_LOG2) : cfg_k_i;
    mask_in   = {AW{1'b1}} >> k_in;
    pre_in    = (cfg_pre_i > {1'b0, mask_in}) ? mask_in : cfg_pre_i[AW-1:0];
    active    = (state_q == ST_ARMED) || (state_q == ST_FILL);
    we        = active && (!qual_en_i || qual_hit_i);
    ready     = (stored_q == pre_q);
    take      = (state_q == ST_ARMED) && we && trig_hit_i && ready;
    post_len  = seg_mask - pre_q;
    fill_last = (state_q == ST_FILL) && we && (rem_q == AW'(1));
    win_end   = (take && (post_len == '0)) || fill_last;
    seg_cnt   = (SIW + 1)'(1) << k_q;
    last_seg  = (seg_q == SIW'(seg_cnt - 1'b1));
    rearm     = (state_q == ST_DONE) && auto_i && rd_en_i && (rd_addr_i == '1);
    begin_run = (((state_q == ST_IDLE) || (state_q == ST_DONE)) && arm_i) || rearm;
    wp_nxt    = (wp_q + 1'b1) & seg_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      wp_q     <= '0;
      stored_q <= '0;
      rem_q    <= '0;
      pre_q    <= '0;
      k_q      <= '0;
      seg_q    <= '0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
    end else if (begin_run) begin
      state_q  <= ST_ARMED;
      k_q      <= k_in;
      pre_q    <= pre_in;
      seg_q    <= '0;
      wp_q     <= '0;
      stored_q <= '0;
    end else begin
      if (we) wp_q <= wp_nxt;
      if ((state_q == ST_ARMED) && we && !ready) stored_q <= stored_q + 1'b1;
      if (win_end) begin
        wp_q     <= '0;
        stored_q <= '0;
        if (last_seg) begin
          state_q <= ST_DONE;
        end else begin
          seg_q   <= seg_q + 1'b1;
          state_q <= ST_ARMED;
        end
      end else if (take) begin
        rem_q   <= post_len;
        state_q <= ST_FILL;
      end else if ((state_q == ST_FILL) && we) begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  // Oldest-sample offset of each window, recorded at its trigger
  always_ff @(posedge clk) begin
    if (take) start_q[seg_q] <= (wp_q - pre_q) & seg_mask;
  end

  assign rd_w      = SIW'(rd_addr_i >> (AW - int'(k_q)));
  assign rd_phys_o = (rd_addr_i & ~seg_mask) | ((start_q[rd_w] + rd_addr_i) & seg_mask);
  assign wr_addr_o = (AW'(seg_q) << (AW - int'(k_q))) | wp_q;
  assign wr_en_o   = we;
  assign state_o   = state_q;
endmodule

// File: rtl/la_capture.sv
module la_capture
  import la_pkg::*;
#(
  parameter int PW           = 4,
  parameter int NPROBE       = 2,
  parameter int DEPTH        = 1024,
  parameter int MAX_SEG_LOG2 = 2,
  localparam int DW = PW * NPROBE,
  localparam int AW = $clog2(DEPTH),
  localparam int KW = $clog2(MAX_SEG_LOG2 + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DW-1:0]       probe_i,
  input  logic                arm_i,
  input  logic                abort_i,
  input  logic                auto_rearm_i,
  input  logic [KW-1:0]       seg_log2_i,
  input  logic [AW:0]         pretrig_i,
  input  logic [2*NPROBE-1:0] trig_mode_i,
  input  logic [DW-1:0]       trig_val_i,
  input  logic                qual_en_i,
  input  logic [2*NPROBE-1:0] qual_mode_i,
  input  logic [DW-1:0]       qual_val_i,
  input  logic                rd_en_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [DW-1:0]       rd_data_o,
  output logic [1:0]          status_o
);
  logic [DW-1:0]     sample_q;
  logic [NPROBE-1:0] prev_q;
  logic              trig_hit, qual_hit, wr_en;
  logic [AW-1:0]     wr_addr, rd_phys;
  la_state_e         state;

  always_ff @(posedge clk) begin
    if (rst) sample_q <= '0;
    else     sample_q <= probe_i;
  end

  for (genvar p = 0; p < NPROBE; p++) begin : g_prev
    always_ff @(posedge clk) begin
      if (rst) prev_q[p] <= 1'b0;
      else     prev_q[p] <= sample_q[PW*p];
    end
  end

  la_match #(.PW(PW), .NPROBE(NPROBE)) u_trig (
    .cur_i(sample_q), .prev_bit_i(prev_q), .mode_i(trig_mode_i),
    .val_i(trig_val_i), .hit_o(trig_hit)
  );

  la_match #(.PW(PW), .NPROBE(NPROBE)) u_qual (
    .cur_i(sample_q), .prev_bit_i(prev_q), .mode_i(qual_mode_i),
    .val_i(qual_val_i), .hit_o(qual_hit)
  );

  la_ctrl #(.DEPTH(DEPTH), .MAX_SEG_LOG2(MAX_SEG_LOG2)) u_ctrl (
    .clk(clk), .rst(rst), .arm_i(arm_i), .abort_i(abort_i),
    .auto_i(auto_rearm_i), .cfg_k_i(seg_log2_i), .cfg_pre_i(pretrig_i),
    .qual_en_i(qual_en_i), .qual_hit_i(qual_hit), .trig_hit_i(trig_hit),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .rd_phys_o(rd_phys), .state_o(state)
  );

  la_trace_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(sample_q),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_phys), .rd_data_o(rd_data_o)
  );

  assign status_o = state;
endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk (
  input logic       clk,
  input logic       rst,
  input logic       arm_i,
  input logic       abort_i,
  input logic       rd_en_i,
  input logic [1:0] status_o
);
  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (status_o == 2'd0));

  assert_arm_start_R2: assert property (@(posedge clk) disable iff (rst)
    (status_o == 2'd0 && arm_i && !abort_i) |=> (status_o == 2'd1));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (status_o == 2'd0 && !arm_i) |=> (status_o == 2'd0));

  assert_done_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (status_o == 2'd3 && !arm_i && !abort_i && !rd_en_i) |=> (status_o == 2'd3));

  assert_fill_no_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (status_o == 2'd2 && !abort_i) |=> (status_o != 2'd0));
endmodule

bind la_capture la_capture_chk u_chk (
  .clk(clk), .rst(rst), .arm_i(arm_i), .abort_i(abort_i),
  .rd_en_i(rd_en_i), .status_o(status_o)
);

// File: tb/la_capture_test.sv
module la_capture_test;
  localparam int PW = 4, NPROBE = 2, DEPTH = 16, MSL = 2;
  localparam int AW = $clog2(DEPTH);
  localparam int KW = $clog2(MSL + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    probe = '0;
  logic          arm = 1'b0, abort = 1'b0, auto_re = 1'b0;
  logic [KW-1:0] segk = '0;
  logic [AW:0]   pre = '0;
  logic [3:0]    tmode = '0, qmode = '0;
  logic [7:0]    tval = '0, qval = '0;
  logic          qen = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic [1:0]    status;

  int   total = 0, bad = 0;
  bit   finished = 1'b0, fill_seen;
  logic [7:0] exp_d [DEPTH];
  logic [7:0] rearm_pa;

  always #5 clk = ~clk;

  la_capture #(.PW(PW), .NPROBE(NPROBE), .DEPTH(DEPTH), .MAX_SEG_LOG2(MSL)) uut (
    .clk(clk), .rst(rst), .probe_i(probe), .arm_i(arm), .abort_i(abort),
    .auto_rearm_i(auto_re), .seg_log2_i(segk), .pretrig_i(pre),
    .trig_mode_i(tmode), .trig_val_i(tval), .qual_en_i(qen),
    .qual_mode_i(qmode), .qual_val_i(qval), .rd_en_i(rd_en),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .status_o(status)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    probe <= probe + 8'd1;
    arm <= 1'b0; abort <= 1'b0; rd_en <= 1'b0;
  endtask

  task automatic arm_at(logic [7:0] pa, string tag);
    @(negedge clk);
    probe <= pa; arm <= 1'b1; abort <= 1'b0; rd_en <= 1'b0;
    tick();
    check({tag, " R2 armed"}, {6'd0, status}, 8'd1);
  endtask

  task automatic run_to_done(string tag);
    int n = 0;
    fill_seen = 1'b0;
    while (status != 2'd3 && n < 3000) begin
      if (status == 2'd2) fill_seen = 1'b1;
      tick();
      n++;
    end
    check({tag, " R6 done"}, {6'd0, status}, 8'd3);
  endtask

  task automatic read_all(string tag);
    for (int a = 0; a <= DEPTH; a++) begin
      @(negedge clk);
      if (a > 0) check($sformatf("%s R7 idx%0d", tag, a - 1), rd_data, exp_d[a - 1]);
      if (a == DEPTH - 1) rearm_pa = probe + 8'd1;
      probe <= probe + 8'd1;
      arm <= 1'b0; abort <= 1'b0;
      if (a < DEPTH) begin
        rd_en <= 1'b1; rd_addr <= AW'(a);
      end else begin
        rd_en <= 1'b0;
      end
    end
  endtask

  function automatic logic [7:0] next_x9(logic [7:0] from);
    logic [7:0] v = from;
    while (v[3:0] != 4'h9) v = v + 8'd1;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst <= 1'b0;
    tick();
    check("R1 reset status", {6'd0, status}, 8'd0);

    // R3 equal on probe0 AND greater on probe1, pretrig 4
    tmode = {2'd2, 2'd1}; tval = 8'h29; pre = 5'd4; segk = '0;
    arm_at(8'h00, "T1");
    run_to_done("T1");
    check("T1 R6 fill seen", {7'd0, fill_seen}, 8'd1);
    for (int i = 0; i < DEPTH; i++) exp_d[i] = 8'h35 + 8'(i);
    read_all("T1 R4 R3");
    repeat (3) tick();
    check("T1 R10 no auto stays done", {6'd0, status}, 8'd3);

    // R5 early match skipped: 0x39 is only 3 samples after arming
    pre = 5'd8;
    arm_at(8'h36, "T2");
    run_to_done("T2");
    for (int i = 0; i < DEPTH; i++) exp_d[i] = 8'h41 + 8'(i);
    read_all("T2 R5");

    // R3 rising edge on probe0 bit 0 AND probe1 == 5
    tmode = {2'd1, 2'd3}; tval = 8'h50; pre = 5'd3;
    arm_at(8'h00, "T3");
    run_to_done("T3");
    for (int i = 0; i < DEPTH; i++) exp_d[i] = 8'h4E + 8'(i);
    read_all("T3 R3 rise");

    // R4 clamp: pretrig 20 becomes 15
    tmode = {2'd1, 2'd1}; tval = 8'h20; pre = 5'd20;
    arm_at(8'h00, "T4");
    run_to_done("T4");
    for (int i = 0; i < DEPTH; i++) exp_d[i] = 8'h11 + 8'(i);
    read_all("T4 R4 clamp");

    // R9 qualifier probe0 == 3; trigger probe1 == 8
    qen = 1'b1; qmode = {2'd0, 2'd1}; qval = 8'h03;
    tmode = {2'd1, 2'd0}; tval = 8'h80; pre = 5'd2;
    arm_at(8'h00, "T5");
    run_to_done("T5");
    for (int i = 0; i < DEPTH; i++) exp_d[i] = 8'h63 + 8'(16 * i);
    read_all("T5 R9");
    qen = 1'b0;

    // R8 four windows of four, trigger probe0 == 9
    segk = 2'd2; tmode = {2'd0, 2'd1}; tval = 8'h09; pre = 5'd1;
    arm_at(8'h00, "T6");
    run_to_done("T6");
    for (int i = 0; i < DEPTH; i++) exp_d[i] = 8'h08 + 8'(16 * (i / 4)) + 8'(i % 4);
    read_all("T6 R8");

    // R10 auto re-arm after last address read
    segk = '0; pre = 5'd2; auto_re = 1'b1;
    arm_at(8'h00, "T7");
    run_to_done("T7");
    for (int i = 0; i < DEPTH; i++) exp_d[i] = 8'h07 + 8'(i);
    read_all("T7a");
    check("T7 R10 rearmed", {6'd0, status}, 8'd1);
    auto_re = 1'b0;
    run_to_done("T7b");
    begin
      logic [7:0] tv;
      tv = next_x9(rearm_pa + 8'd2);
      for (int i = 0; i < DEPTH; i++) exp_d[i] = tv - 8'd2 + 8'(i);
    end
    read_all("T7b R10");

    // R11 abort while armed, then R12 idle ignores matches
    tmode = {2'd1, 2'd1}; tval = 8'hFF; pre = 5'd0;
    arm_at(8'h00, "T8");
    repeat (4) tick();
    @(negedge clk); abort <= 1'b1; probe <= probe + 8'd1;
    tick();
    check("T8 R11 abort armed", {6'd0, status}, 8'd0);
    repeat (300) tick();
    check("T8 R12 idle holds", {6'd0, status}, 8'd0);

    // R11 abort while filling
    tval = 8'h10;
    arm_at(8'h0C, "T9");
    begin
      int n = 0;
      while (status != 2'd2 && n < 100) begin tick(); n++; end
    end
    check("T9 R6 filling", {6'd0, status}, 8'd2);
    @(negedge clk); abort <= 1'b1; probe <= probe + 8'd1;
    tick();
    check("T9 R11 abort fill", {6'd0, status}, 8'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule